// File: doc/BRIEF.md
# Warp Issue Selector with Thread-Block Barrier

This block sits between the per-warp instruction buffers and the execution back end of a streaming processor. In every cycle it looks at the oldest buffered instruction of each warp and decides which warp may issue. It then picks one such warp in round-robin order. When the chosen instruction is an ordinary operation, the block sends it to the memory, SP or SFU pipeline. In the same cycle it asks the scoreboard to reserve the instruction's destination register.

A barrier instruction takes no functional unit. Issuing it only records that the warp has arrived at the barrier of its thread block, and the warp then stays parked. Thread-block membership is given as one warp mask per block. When every warp in a block's mask has arrived, the block's arrival vector is cleared and all of its warps resume together. Fetch, divergence handling and the scoreboard contents are handled outside this block. Only the scoreboard's per-warp pass/fail result comes in.

Top module: `warp_issue_sel`

## Requirements
- R1: A warp can issue only when its buffer holds a valid instruction (`ibuf_valid_i[w]`=1) and its dependency check has passed (`dep_ok_i[w]`=1).
- R2: A warp that has arrived at a barrier that has not yet released does not issue, even when it holds a valid instruction.
- R3: While `opnd_stall_i` is 1, no warp issues: `issue_o`, `pop_o`, `rsv_o` and `pipe_valid_o` are all 0.
- R4: A non-barrier instruction carries a 2-bit target code: 0 is memory, 1 is SP, 2 is SFU, and 3 is reserved. Such an instruction issues only if its target's busy bit is 0. An instruction with code 3 never issues unless it is a barrier. A barrier ignores the busy bits.
- R5: Among the warps that may issue, the winner is the first one found when searching upward, with wrap-around, from the warp just after the last warp that issued.
- R6: On issue, `issue_o`=1, `issue_warp_o` holds the index of the winning warp, and `pop_o` has exactly that warp's bit set. With no issue, `issue_o`=0 and `pop_o`=0.
- R7: A non-barrier issue sets `rsv_o`=1 with `rsv_dst_o` equal to that warp's destination field. It also sets exactly one bit of `pipe_valid_o`: bit 0 for memory, bit 1 for SP, bit 2 for SFU.
- R8: A barrier issue (`ibuf_bar_i[w]`=1) leaves `rsv_o` and `pipe_valid_o` at 0. From the next cycle on, it marks the warp as arrived in every block whose mask contains it.
- R9: Take a block whose mask is not zero. When all warps in its mask have arrived, `bar_release_o[b]` is 1 for one cycle, and in the following cycle all of those warps may issue again. A warp that is in no block never waits after a barrier.
- R10: After reset, no warp has arrived and the round-robin search starts at warp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ibuf_valid_i | input | N_WARPS | Per warp: a buffered instruction is present |
| ibuf_bar_i | input | N_WARPS | Per warp: the buffered instruction is a barrier |
| ibuf_pipe_i | input | 2*N_WARPS | Per warp: 2-bit target pipeline code |
| ibuf_dst_i | input | REG_W*N_WARPS | Per warp: destination register index |
| dep_ok_i | input | N_WARPS | Per warp: the scoreboard dependency check passed |
| opnd_stall_i | input | 1 | Operand stage stall |
| pipe_busy_i | input | 3 | Busy bits for memory, SP and SFU |
| blk_mask_i | input | N_BLOCKS*N_WARPS | Warp membership mask per thread block |
| issue_o | output | 1 | An instruction issues this cycle |
| issue_warp_o | output | WID_W | Index of the issuing warp |
| pop_o | output | N_WARPS | One-hot pop to the instruction buffers |
| rsv_o | output | 1 | Destination register reserve request |
| rsv_dst_o | output | REG_W | Register to reserve |
| pipe_valid_o | output | 3 | Dispatch strobe for memory, SP and SFU |
| bar_release_o | output | N_BLOCKS | Barrier release pulse per block |

## Verification
Barrier release and ordinary issue can happen in the same cycle. One block's release pulse can coincide with a grant to a warp outside that block, and the warps just released are still barred in that cycle. The random phase mixes rare barrier instructions into dense traffic, so releases land while other warps are competing for issue. A directed sequence also parks all of one block while an unrelated warp keeps issuing. In every cycle, the bench model predicts the release pulse, the grant and the point at which the parked warps may issue again, and compares all three.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned PIPE_N = 3;
  typedef enum logic [1:0] {
    PIPE_MEM = 2'd0,
    PIPE_SP  = 2'd1,
    PIPE_SFU = 2'd2,
    PIPE_RSV = 2'd3
  } pipe_e;
endpackage

// File: rtl/wis_elig.sv
module wis_elig import wis_pkg::*; #(
  parameter int unsigned N_WARPS = 8
) (
  input  logic [N_WARPS-1:0]   valid_i,
  input  logic [N_WARPS-1:0]   bar_i,
  input  logic [2*N_WARPS-1:0] pipe_i,
  input  logic [N_WARPS-1:0]   dep_ok_i,
  input  logic [N_WARPS-1:0]   wait_i,
  input  logic                 stall_i,
  input  logic [PIPE_N-1:0]    busy_i,
  output logic [N_WARPS-1:0]   elig_o
);
  logic [3:0] busy_ext;
  assign busy_ext = {1'b1, busy_i};  // reserved code always blocked

  for (genvar w = 0; w < N_WARPS; w++) begin : g_w
    logic [1:0] code;
    assign code = pipe_i[2*w +: 2];
    assign elig_o[w] = valid_i[w] & dep_ok_i[w] & ~wait_i[w] & ~stall_i &
                       (bar_i[w] | ~busy_ext[code]);
  end
endmodule

// File: rtl/wis_rr_arb.sv
module wis_rr_arb #(
  parameter int unsigned N       = 8,
  localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     gnt_o
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int c;
      c = (int'(last_q) + k) % int'(N);
      if (!any_o && req_i[c]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(c);
      end
    end
    gnt_o = any_o ? (N'(1) << idx_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IDX_W'(N - 1);
    else if (any_o) last_q <= idx_o;
  end

  // R6
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R1
  gnt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/wis_barrier.sv
module wis_barrier #(
  parameter int unsigned N_WARPS  = 8,
  parameter int unsigned N_BLOCKS = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_WARPS-1:0]            arrive_i,
  input  logic [N_BLOCKS*N_WARPS-1:0]   mask_i,
  output logic [N_WARPS-1:0]            wait_o,
  output logic [N_BLOCKS-1:0]           rel_o
);
  logic [N_WARPS-1:0] arr_q [N_BLOCKS];

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_blk
    logic [N_WARPS-1:0] mask;
    assign mask     = mask_i[N_WARPS*b +: N_WARPS];
    assign rel_o[b] = (mask != '0) && ((arr_q[b] & mask) == mask);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       arr_q[b] <= '0;
      else if (rel_o[b]) arr_q[b] <= '0;
      else               arr_q[b] <= arr_q[b] | (arrive_i & mask);
    end

    // R9
    release_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_o[b] |=> !rel_o[b]);
  end

  always_comb begin
    wait_o = '0;
    for (int b = 0; b < int'(N_BLOCKS); b++) wait_o |= arr_q[b];
  end

  // R2
  no_rearrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arrive_i & wait_o) == '0);
endmodule

// File: rtl/warp_issue_sel.sv
module warp_issue_sel import wis_pkg::*; #(
  parameter int unsigned N_WARPS  = 8,
  parameter int unsigned N_BLOCKS = 2,
  parameter int unsigned REG_W    = 6,
  localparam int unsigned WID_W   = (N_WARPS > 1) ? $clog2(N_WARPS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_WARPS-1:0]          ibuf_valid_i,
  input  logic [N_WARPS-1:0]          ibuf_bar_i,
  input  logic [2*N_WARPS-1:0]        ibuf_pipe_i,
  input  logic [REG_W*N_WARPS-1:0]    ibuf_dst_i,
  input  logic [N_WARPS-1:0]          dep_ok_i,
  input  logic                        opnd_stall_i,
  input  logic [PIPE_N-1:0]           pipe_busy_i,
  input  logic [N_BLOCKS*N_WARPS-1:0] blk_mask_i,
  output logic                        issue_o,
  output logic [WID_W-1:0]            issue_warp_o,
  output logic [N_WARPS-1:0]          pop_o,
  output logic                        rsv_o,
  output logic [REG_W-1:0]            rsv_dst_o,
  output logic [PIPE_N-1:0]           pipe_valid_o,
  output logic [N_BLOCKS-1:0]         bar_release_o
);
  logic [N_WARPS-1:0] wait_w, elig, gnt, arrive;
  logic               any;
  logic [WID_W-1:0]   idx;
  logic               sel_bar;
  logic [1:0]         sel_pipe;
  logic [REG_W-1:0]   sel_dst;

  wis_elig #(.N_WARPS(N_WARPS)) u_elig (
    .valid_i(ibuf_valid_i), .bar_i(ibuf_bar_i), .pipe_i(ibuf_pipe_i),
    .dep_ok_i(dep_ok_i), .wait_i(wait_w), .stall_i(opnd_stall_i),
    .busy_i(pipe_busy_i), .elig_o(elig)
  );

  wis_rr_arb #(.N(N_WARPS)) u_arb (
    .clk_i, .rst_ni, .req_i(elig), .any_o(any), .idx_o(idx), .gnt_o(gnt)
  );

  always_comb begin
    sel_bar  = 1'b0;
    sel_pipe = '0;
    sel_dst  = '0;
    for (int w = 0; w < int'(N_WARPS); w++) begin
      if (gnt[w]) begin
        sel_bar  = ibuf_bar_i[w];
        sel_pipe = ibuf_pipe_i[2*w +: 2];
        sel_dst  = ibuf_dst_i[REG_W*w +: REG_W];
      end
    end
  end

  assign arrive = (any && sel_bar) ? gnt : '0;

  wis_barrier #(.N_WARPS(N_WARPS), .N_BLOCKS(N_BLOCKS)) u_bar (
    .clk_i, .rst_ni, .arrive_i(arrive), .mask_i(blk_mask_i),
    .wait_o(wait_w), .rel_o(bar_release_o)
  );

  assign issue_o      = any;
  assign issue_warp_o = idx;
  assign pop_o        = gnt;
  assign rsv_o        = any & ~sel_bar;
  assign rsv_dst_o    = sel_dst;
  assign pipe_valid_o = rsv_o ? (PIPE_N'(1) << sel_pipe) : '0;

  // R3
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_stall_i |-> !issue_o && pipe_valid_o == '0);
  // R1
  issue_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> ibuf_valid_i[issue_warp_o] && dep_ok_i[issue_warp_o]);
  // R7
  rsv_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_o |-> $countones(pipe_valid_o) == 1);
  // R8
  bar_no_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && ibuf_bar_i[issue_warp_o]) |-> !rsv_o && pipe_valid_o == '0);
  // R4
  busy_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_valid_o & pipe_busy_i) == '0);
endmodule

// File: tb/warp_issue_sel_bench.sv
module warp_issue_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int NB = 2;
  localparam int RW = 6;

  logic clk = 0, rst_n = 0;
  logic [NW-1:0]    valid, bar, dep;
  logic [2*NW-1:0]  pipe;
  logic [RW*NW-1:0] dst;
  logic             stall;
  logic [2:0]       busy;
  logic [NB*NW-1:0] mask;
  logic             issue, rsv;
  logic [2:0]       iwarp, pv;
  logic [NW-1:0]    pop;
  logic [RW-1:0]    rdst;
  logic [NB-1:0]    rel;

  int total = 0, bad = 0;
  int last;
  logic [NW-1:0] arr [NB];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sel #(.N_WARPS(NW), .N_BLOCKS(NB), .REG_W(RW)) u_warp_issue_sel (
    .clk_i(clk), .rst_ni(rst_n), .ibuf_valid_i(valid), .ibuf_bar_i(bar),
    .ibuf_pipe_i(pipe), .ibuf_dst_i(dst), .dep_ok_i(dep), .opnd_stall_i(stall),
    .pipe_busy_i(busy), .blk_mask_i(mask), .issue_o(issue), .issue_warp_o(iwarp),
    .pop_o(pop), .rsv_o(rsv), .rsv_dst_o(rdst), .pipe_valid_o(pv),
    .bar_release_o(rel)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] mwait();
    logic [NW-1:0] r = '0;
    for (int b = 0; b < NB; b++) r |= arr[b];
    return r;
  endfunction

  function automatic logic complete(int b);
    logic [NW-1:0] m = mask[NW*b +: NW];
    return (m != '0) && ((arr[b] & m) == m);
  endfunction

  // one cycle: check outputs against model, then advance model past the edge
  task automatic step(string tag);
    logic [NW-1:0] el, wv;
    logic          any;
    int            win;
    logic [1:0]    code;
    #1;
    wv = mwait();
    for (int w = 0; w < NW; w++) begin
      code = pipe[2*w +: 2];
      el[w] = valid[w] && dep[w] && !wv[w] && !stall &&
              (bar[w] || (code != 2'd3 && !busy[code]));
    end
    any = 0; win = 0;
    for (int k = 1; k <= NW; k++) begin
      int c = (last + k) % NW;
      if (!any && el[c]) begin any = 1; win = c; end
    end
    chk({tag, " issue R6"}, issue, any);
    chk({tag, " pop R6"}, pop, any ? (64'd1 << win) : 64'd0);
    if (any) chk({tag, " warp R5"}, iwarp, win);
    chk({tag, " rsv R7"}, rsv, any && !bar[win]);
    if (any && !bar[win]) begin
      chk({tag, " dst R7"}, rdst, dst[RW*win +: RW]);
      chk({tag, " pipe R7"}, pv, 64'd1 << pipe[2*win +: 2]);
    end else chk({tag, " pipe R8"}, pv, 0);
    for (int b = 0; b < NB; b++) chk({tag, " release R9"}, rel[b], complete(b));
    @(posedge clk);
    for (int b = 0; b < NB; b++) begin
      if (complete(b)) arr[b] = '0;
      else if (any && bar[win]) arr[b] |= (NW'(1) << win) & mask[NW*b +: NW];
    end
    if (any) last = win;
    @(negedge clk);
  endtask

  task automatic idle();
    valid = '0; bar = '0; dep = '1; stall = 0; busy = '0;
    pipe = {NW{2'd1}};
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    mask = {8'h70, 8'h0F};  // block0: warps 0-3, block1: warps 4-6, warp 7 in none
    for (int w = 0; w < NW; w++) dst[RW*w +: RW] = RW'(w * 5 + 3);
    idle();
    last = NW - 1;
    for (int b = 0; b < NB; b++) arr[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: nothing pending, then all valid -> warp 0 first
    step("R10 empty");
    valid = '1; step("R10 first");
    valid = '0; valid[3] = 1; dep[3] = 0; step("R1 dep low");
    dep[3] = 1; step("R1 dep high");
    valid = '1; stall = 1; step("R3 stall"); stall = 0;
    valid = 8'b0010_0100; pipe[5:4] = 2'd2; busy = 3'b100; step("R4 busy sfu");
    busy = 0; valid = 8'b0000_0100; pipe[5:4] = 2'd3; step("R4 reserved code");
    pipe[5:4] = 2'd1;
    // barrier on block1
    idle(); valid[4] = 1; bar[4] = 1; step("R8 bar w4");
    bar[4] = 0; step("R2 w4 parked");
    valid[7] = 1; bar[7] = 1; step("R9 w7 no block");
    bar[7] = 0; valid[4] = 0; step("R9 w7 free");
    valid = 8'b0110_0000; bar = 8'b0110_0000; step("R8 bar w5");
    step("R8 bar w6");
    idle(); valid = 8'b1111_0000; step("R9 release with w7");
    step("R9 resumed");
    step("R9 resumed2");

    // random phase
    for (int i = 0; i < 1500; i++) begin
      for (int w = 0; w < NW; w++) begin
        valid[w] = ($urandom % 4) != 0;
        dep[w]   = ($urandom % 4) != 0;
        bar[w]   = ($urandom % 10) == 0;
        pipe[2*w +: 2] = 2'($urandom % 4);
        dst[RW*w +: RW] = RW'($urandom);
      end
      stall = ($urandom % 10) == 0;
      busy  = {($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0};
      step("rand");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule